// File: doc/BRIEF.md
# Accumulator Add Execution Unit

This block executes the three byte-wide accumulator additions of a small 8-bit processor core. An opcode byte arrives from the fetch stage with a valid strobe. The unit accepts it only when idle and when it is one of the supported addition opcodes. It then steps through machine cycles and clock states, one clock per state. The second operand comes from one of three places: a register of its own seven-entry register bank, an immediate byte that follows the opcode in the instruction stream, or a memory byte addressed by the H:L register pair. At the end the unit writes the sum into the accumulator and loads the condition flags.

Each addressing form has a fixed length. The register form takes one machine cycle of four states. The immediate and memory forms add a second machine cycle of three states, and that cycle carries the memory read. The current machine cycle and state number are visible at the ports. After each instruction the total number of states it used is reported. A register write port lets the surrounding core load the bank. A write to the accumulator that lands on the same edge as the unit's own write-back is dropped.

Top module: `acc_add_unit`

## Requirements
- R1: After reset, accOut and flagsOut are 00h, opReady is 1, done and memRd are 0, and mCycle and tState are 0.
- R2: Opcode 10000sss adds a bank register to A, with sss coding 000=B, 001=C, 010=D, 011=E, 100=H, 101=L and 111=A. The low 8 bits of the sum replace A.
- R3: Opcode C6h adds an immediate byte. memRd is high with memImm=1 during states 1 and 2 of machine cycle 2. memData is captured on the edge that ends state 2.
- R4: Opcode 86h adds the byte at address {H,L}. During its read, memAddr equals {H,L} and memImm is 0.
- R5: flagsOut bit 7 (sign) equals bit 7 of the result, bit 6 (zero) is set when the result is 00h, and bit 0 (carry) is set on a carry out of bit 7.
- R6: flagsOut bit 4 (half-carry) is set on a carry out of bit 3. Bit 2 (overflow) is set when the signed sum of the two operands falls outside -128..127. Bit 1 (subtract) is always 0, and bits 5 and 3 are always 0.
- R7: The register form runs machine cycle 1 only, over states 1 to 4. The other two forms run machine cycle 1 over states 1 to 4, then machine cycle 2 over states 1 to 3. mCycle and tState show the current position counted from 1, and instrStates shows 4 or 7 after the instruction ends.
- R8: done is high for exactly the final state. A and the flags change only on the edge that ends that state.
- R9: An opcode outside 80h-85h, 87h, 86h and C6h is discarded: opReady stays 1, done never rises, and A and the flags are unchanged.
- R10: opReady is 1 only while idle. An opValid presented while busy is ignored.
- R11: A register-port write to A on the edge where done is high is discarded. A write to any other register on that edge takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one state per cycle |
| rstN | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | Opcode byte is presented |
| opByte | input | 8 | Opcode from the fetch stage |
| opReady | output | 1 | Unit idle, opcode can be accepted |
| regWrEn | input | 1 | Register bank write strobe |
| regWrSel | input | 3 | Register code to write (same codes as R2) |
| regWrData | input | DATA_W | Value to write |
| memRd | output | 1 | Operand memory read in progress |
| memImm | output | 1 | Read is the immediate byte of the instruction stream |
| memAddr | output | 2*DATA_W | Pointer address {H,L} for the memory form, else 0 |
| memData | input | DATA_W | Byte returned by memory |
| accOut | output | DATA_W | Accumulator contents |
| flagsOut | output | 8 | Condition flags |
| done | output | 1 | Final state of the instruction |
| mCycle | output | 2 | Current machine cycle, 0 when idle |
| tState | output | T_W | Current state within the machine cycle, 0 when idle |
| instrStates | output | C_W | State count of the last completed instruction |

## Verification
Two writes to the accumulator can meet on one edge: the unit's sum write-back and a write arriving on the register port. The bench waits for the cycle in which done is high and drives a port write to A in that same cycle. It checks that A holds the sum afterwards. In the same kind of cycle it writes register C and proves that write landed, by a later addition that uses C as its source. The bench also holds opValid high through a busy instruction to confirm that no second instruction starts.

// File: rtl/acc_add_pkg.sv
package acc_add_pkg;

  typedef enum logic [1:0] {
    FORM_REG = 2'd0,
    FORM_IMM = 2'd1,
    FORM_IND = 2'd2
  } addForm_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       grabOperand;  // capture memory byte
    logic       commit;       // write sum into A and flags
    logic       rdPtr;        // drive {H,L} onto the address bus
    addForm_e   form;
    logic [2:0] srcSel;
  } ctrlStrobe_t;

  localparam logic [2:0] SEL_H   = 3'b100;
  localparam logic [2:0] SEL_L   = 3'b101;
  localparam logic [2:0] SEL_IND = 3'b110;
  localparam logic [2:0] SEL_A   = 3'b111;

  localparam logic [7:0] OP_IMM = 8'hC6;
  localparam logic [7:0] OP_IND = 8'h86;
  localparam logic [4:0] OP_REG_TOP = 5'b10000;

  localparam int FLAG_S  = 7;
  localparam int FLAG_Z  = 6;
  localparam int FLAG_H  = 4;
  localparam int FLAG_PV = 2;
  localparam int FLAG_N  = 1;
  localparam int FLAG_C  = 0;

endpackage

// File: rtl/acc_add_ctrl.sv
module acc_add_ctrl
  import acc_add_pkg::*;
#(
  parameter int M1_STATES = 4,
  parameter int M2_STATES = 3,
  parameter int T_W       = 3,
  parameter int C_W       = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           opValid,
  input  logic [7:0]     opByte,
  output logic           opReady,
  output logic           memRd,
  output logic           memImm,
  output logic           done,
  output logic [1:0]     mCycle,
  output logic [T_W-1:0] tState,
  output logic [C_W-1:0] instrStates,
  output ctrlStrobe_t    ctrl
);

  localparam int SAMPLE_T = M2_STATES - 1;
  localparam logic [T_W-1:0] M1_LAST  = T_W'(M1_STATES);
  localparam logic [T_W-1:0] M2_LAST  = T_W'(M2_STATES);
  localparam logic [T_W-1:0] M2_GRAB  = T_W'(SAMPLE_T);

  logic           busy;
  addForm_e       form;
  logic [2:0]     srcSel;
  logic [1:0]     mCyc;
  logic [T_W-1:0] tSt;
  logic [C_W-1:0] stateCnt;

  logic isReg, isImm, isInd, accept, lastState, endOfM1;

  // opcode decode
  always_comb begin
    isReg  = (opByte[7:3] == OP_REG_TOP) && (opByte[2:0] != SEL_IND);
    isImm  = (opByte == OP_IMM);
    isInd  = (opByte == OP_IND);
    accept = !busy && opValid && (isReg || isImm || isInd);
  end

  always_comb begin
    endOfM1   = busy && (mCyc == 2'd1) && (tSt == M1_LAST);
    lastState = busy && (((form == FORM_REG) && endOfM1) ||
                         ((form != FORM_REG) && (mCyc == 2'd2) && (tSt == M2_LAST)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy        <= 1'b0;
      form        <= FORM_REG;
      srcSel      <= '0;
      mCyc        <= '0;
      tSt         <= '0;
      stateCnt    <= '0;
      instrStates <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      form     <= isImm ? FORM_IMM : (isInd ? FORM_IND : FORM_REG);
      srcSel   <= opByte[2:0];
      mCyc     <= 2'd1;
      tSt      <= T_W'(1);
      stateCnt <= C_W'(1);
    end else if (busy) begin
      if (lastState) begin
        busy        <= 1'b0;
        mCyc        <= '0;
        tSt         <= '0;
        instrStates <= stateCnt;
        stateCnt    <= '0;
      end else if (endOfM1) begin
        mCyc     <= 2'd2;
        tSt      <= T_W'(1);
        stateCnt <= stateCnt + 1'b1;
      end else begin
        tSt      <= tSt + 1'b1;
        stateCnt <= stateCnt + 1'b1;
      end
    end
  end

  always_comb begin
    opReady = !busy;
    done    = lastState;
    mCycle  = mCyc;
    tState  = tSt;
    memRd   = busy && (form != FORM_REG) && (mCyc == 2'd2) && (tSt <= M2_GRAB);
    memImm  = memRd && (form == FORM_IMM);

    ctrl.grabOperand = memRd && (tSt == M2_GRAB);
    ctrl.commit      = lastState;
    ctrl.rdPtr       = memRd && (form == FORM_IND);
    ctrl.form        = form;
    ctrl.srcSel      = srcSel;
  end

endmodule

// File: rtl/acc_add_dpath.sv
module acc_add_dpath
  import acc_add_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       ctrl,
  input  logic              regWrEn,
  input  logic [2:0]        regWrSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] accOut,
  output logic [7:0]        flagsOut
);

  localparam int NIB = DATA_W / 2;
  localparam int MSB = DATA_W - 1;
  localparam int NREG = 8;

  logic [DATA_W-1:0] regBank [NREG];
  logic [DATA_W-1:0] memLatch;
  logic [DATA_W-1:0] opA, opB, sum;
  logic [DATA_W:0]   fullSum;
  logic [NIB:0]      lowSum;
  logic [7:0]        newFlags;
  logic              halfCarry, overflow;

  // operand selection
  always_comb begin
    opA = regBank[SEL_A];
    opB = (ctrl.form == FORM_REG) ? regBank[ctrl.srcSel] : memLatch;
  end

  // adder with low-half carry and signed overflow
  always_comb begin
    fullSum   = {1'b0, opA} + {1'b0, opB};
    lowSum    = {1'b0, opA[NIB-1:0]} + {1'b0, opB[NIB-1:0]};
    sum       = fullSum[DATA_W-1:0];
    halfCarry = lowSum[NIB];
    overflow  = (opA[MSB] == opB[MSB]) && (sum[MSB] != opA[MSB]);

    newFlags          = '0;
    newFlags[FLAG_S]  = sum[MSB];
    newFlags[FLAG_Z]  = (sum == '0);
    newFlags[FLAG_H]  = halfCarry;
    newFlags[FLAG_PV] = overflow;
    newFlags[FLAG_N]  = 1'b0;
    newFlags[FLAG_C]  = fullSum[DATA_W];
  end

  // register bank: write-back takes A over the external port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regBank[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (3'(i) != SEL_IND) begin
          if (ctrl.commit && (3'(i) == SEL_A))
            regBank[i] <= sum;
          else if (regWrEn && (regWrSel == 3'(i)))
            regBank[i] <= regWrData;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memLatch <= '0;
      flagsOut <= '0;
    end else begin
      if (ctrl.grabOperand) memLatch <= memData;
      if (ctrl.commit)      flagsOut <= newFlags;
    end
  end

  always_comb begin
    accOut  = regBank[SEL_A];
    memAddr = ctrl.rdPtr ? ADDR_W'({regBank[SEL_H], regBank[SEL_L]}) : '0;
  end

endmodule

// File: rtl/acc_add_unit.sv
module acc_add_unit
  import acc_add_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int M1_STATES = 4,
  parameter int M2_STATES = 3,
  parameter int ADDR_W    = 2 * DATA_W,
  parameter int T_W       = $clog2(M1_STATES + 1),
  parameter int C_W       = $clog2(M1_STATES + M2_STATES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [7:0]        opByte,
  output logic              opReady,
  input  logic              regWrEn,
  input  logic [2:0]        regWrSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic              memRd,
  output logic              memImm,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] accOut,
  output logic [7:0]        flagsOut,
  output logic              done,
  output logic [1:0]        mCycle,
  output logic [T_W-1:0]    tState,
  output logic [C_W-1:0]    instrStates
);

  ctrlStrobe_t ctrl;

  acc_add_ctrl #(
    .M1_STATES(M1_STATES),
    .M2_STATES(M2_STATES),
    .T_W      (T_W),
    .C_W      (C_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .opValid    (opValid),
    .opByte     (opByte),
    .opReady    (opReady),
    .memRd      (memRd),
    .memImm     (memImm),
    .done       (done),
    .mCycle     (mCycle),
    .tState     (tState),
    .instrStates(instrStates),
    .ctrl       (ctrl)
  );

  acc_add_dpath #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .regWrEn  (regWrEn),
    .regWrSel (regWrSel),
    .regWrData(regWrData),
    .memData  (memData),
    .memAddr  (memAddr),
    .accOut   (accOut),
    .flagsOut (flagsOut)
  );

endmodule

// File: rtl/acc_add_checker.sv
module acc_add_checker #(
  parameter int DATA_W    = 8,
  parameter int M1_STATES = 4,
  parameter int M2_STATES = 3,
  parameter int T_W       = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              opReady,
  input logic              memRd,
  input logic              memImm,
  input logic              done,
  input logic [1:0]        mCycle,
  input logic [T_W-1:0]    tState,
  input logic [DATA_W-1:0] accOut,
  input logic [7:0]        flagsOut
);

  // R7
  reg_form_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && mCycle == 2'd1) |-> (tState == T_W'(M1_STATES)));

  // R7
  mem_form_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && mCycle == 2'd2) |-> (tState == T_W'(M2_STATES)));

  // R3
  read_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> (mCycle == 2'd2 && !opReady && !done));

  // R3
  read_span_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && tState == T_W'(1)) |=> (memRd && $stable(memImm)));

  // R10
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> opReady);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    opReady |-> (!memRd && !done && mCycle == 2'd0));

  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |=> $stable(flagsOut));

  // R5
  sign_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (flagsOut[7] == accOut[DATA_W-1]) && (flagsOut[6] == (accOut == '0)));

  // R6
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (flagsOut[1] == 1'b0 && flagsOut[5] == 1'b0 && flagsOut[3] == 1'b0));

endmodule

bind acc_add_unit acc_add_checker #(
  .DATA_W   (DATA_W),
  .M1_STATES(M1_STATES),
  .M2_STATES(M2_STATES),
  .T_W      (T_W)
) u_accAddChk (
  .clk     (clk),
  .rstN    (rstN),
  .opReady (opReady),
  .memRd   (memRd),
  .memImm  (memImm),
  .done    (done),
  .mCycle  (mCycle),
  .tState  (tState),
  .accOut  (accOut),
  .flagsOut(flagsOut)
);

// File: tb/test_acc_add_unit.sv
`timescale 1ns/1ps
module test_acc_add_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [7:0]  opByte = '0;
  logic        opReady;
  logic        regWrEn = 1'b0;
  logic [2:0]  regWrSel = '0;
  logic [7:0]  regWrData = '0;
  logic        memRd, memImm;
  logic [15:0] memAddr;
  logic [7:0]  memData = '0;
  logic [7:0]  accOut, flagsOut;
  logic        done;
  logic [1:0]  mCycle;
  logic [2:0]  tState;
  logic [2:0]  instrStates;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  int gotStates, rdCycles, rdMc, rdTs, firstMc, firstTs, doneMc, doneTs;
  int rdAddr, rdImm;
  bit timedOut;

  always #2 clk = ~clk;  // 250 MHz

  acc_add_unit i_acc_add_unit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opByte(opByte), .opReady(opReady),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .memRd(memRd), .memImm(memImm), .memAddr(memAddr), .memData(memData),
    .accOut(accOut), .flagsOut(flagsOut), .done(done), .mCycle(mCycle),
    .tState(tState), .instrStates(instrStates)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [7:0] expFlags(input int a, input int b);
    int s, r, sa, sb, ss;
    logic [7:0] f;
    s  = a + b;
    r  = s % 256;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    ss = sa + sb;
    f = '0;
    f[7] = (r > 127);
    f[6] = (r == 0);
    f[4] = ((a % 16) + (b % 16)) > 15;
    f[2] = (ss > 127) || (ss < -128);
    f[0] = (s > 255);
    return f;
  endfunction

  task automatic setReg(input logic [2:0] sel, input logic [7:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = sel; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic issue(input logic [7:0] op);
    @(negedge clk);
    opValid = 1'b1; opByte = op;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic execute(input logic [7:0] op, input logic [7:0] mb);
    memData = mb;
    issue(op);
    gotStates = 0; rdCycles = 0; rdAddr = 0; rdImm = 0; rdMc = 0; rdTs = 0;
    firstMc = int'(mCycle); firstTs = int'(tState); timedOut = 1'b0;
    forever begin
      gotStates++;
      if (memRd) begin
        if (rdCycles == 0) begin
          rdAddr = int'(memAddr); rdImm = int'(memImm);
          rdMc = int'(mCycle); rdTs = int'(tState);
        end
        rdCycles++;
      end
      if (done) begin
        doneMc = int'(mCycle); doneTs = int'(tState);
        break;
      end
      if (gotStates > 20) begin
        timedOut = 1'b1;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    if (timedOut) check(1'b0, "R8 done never raised", 0, 1);
  endtask

  // checks result and flags of A + b
  task automatic judge(input string tag, input int a, input int b);
    int expSum;
    logic [7:0] expF;
    expSum = (a + b) % 256;
    expF = expFlags(a, b);
    check(int'(accOut) == expSum, {tag, " R2 sum"}, int'(accOut), expSum);
    check(flagsOut[7:6] == expF[7:6] && flagsOut[0] == expF[0],
          {tag, " R5 S/Z/C"}, int'(flagsOut), int'(expF));
    check(flagsOut[5:1] == expF[5:1], {tag, " R6 H/PV/N"}, int'(flagsOut), int'(expF));
  endtask

  initial begin
    int aVals[6];
    int expA;
    bit sawDone;

    // reset state
    #9 rstN = 1'b1;
    @(negedge clk);
    check(accOut == 8'h00 && flagsOut == 8'h00, "R1 reset A/flags", {accOut, flagsOut}, 0);
    check(opReady && !done && !memRd, "R1 reset idle", {opReady, done, memRd}, 3'b100);
    check(mCycle == 0 && tState == 0, "R1 reset position", {mCycle, tState}, 0);

    // worked examples
    setReg(3'b111, 8'h44); setReg(3'b001, 8'h11);
    execute(8'h81, 8'h00);
    judge("ex reg", 'h44, 'h11);
    check(accOut == 8'h55, "R2 44h+11h", accOut, 'h55);

    setReg(3'b111, 8'h23);
    execute(8'hC6, 8'h33);
    check(accOut == 8'h56, "R3 23h+33h", accOut, 'h56);
    check(rdImm == 1 && rdCycles == 2, "R3 immediate read strobes", rdImm * 16 + rdCycles, 'h12);
    check(rdMc == 2 && rdTs == 1, "R3 read starts M2 state 1", rdMc * 16 + rdTs, 'h21);

    setReg(3'b111, 8'hA0); setReg(3'b100, 8'h23); setReg(3'b101, 8'h23);
    execute(8'h86, 8'h08);
    check(accOut == 8'hA8, "R4 A0h+(HL)", accOut, 'hA8);
    check(rdAddr == 'h2323 && rdImm == 0, "R4 pointer address", rdAddr, 'h2323);
    check(gotStates == 7 && instrStates == 7, "R7 memory form 7 states", gotStates, 7);
    check(doneMc == 2 && doneTs == 3, "R7 memory form end M2 state 3", doneMc * 16 + doneTs, 'h23);

    // sweep A over every value against boundary operands through register B
    aVals = '{0, 0, 0, 0, 0, 0};
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 8; k++) begin
        int b;
        case (k)
          0: b = 'h00; 1: b = 'h01; 2: b = 'h0F; 3: b = 'h10;
          4: b = 'h7F; 5: b = 'h80; 6: b = 'hFF; default: b = (a * 7 + 3) % 256;
        endcase
        setReg(3'b111, 8'(a)); setReg(3'b000, 8'(b));
        execute(8'h80, 8'h00);
        judge("sweep reg B", a, b);
        if (a == 0 && k == 0) begin
          check(gotStates == 4 && instrStates == 4, "R7 register form 4 states", gotStates, 4);
          check(firstMc == 1 && firstTs == 1 && doneMc == 1 && doneTs == 4,
                "R7 register form positions", firstTs * 16 + doneTs, 'h14);
          check(rdCycles == 0, "R3 register form no read", rdCycles, 0);
        end
      end
    end

    // immediate form over every operand for several accumulator values
    aVals = '{'h00, 'h01, 'h7F, 'h80, 'h88, 'hFF};
    for (int i = 0; i < 6; i++) begin
      for (int b = 0; b < 256; b++) begin
        setReg(3'b111, 8'(aVals[i]));
        execute(8'hC6, 8'(b));
        judge("sweep imm", aVals[i], b);
      end
    end

    // every register code, distinct contents
    for (int c = 0; c < 8; c++) begin
      int srcVal;
      if (c == 6) continue;
      setReg(3'b000, 8'h11); setReg(3'b001, 8'h22); setReg(3'b010, 8'h33);
      setReg(3'b011, 8'h44); setReg(3'b100, 8'h55); setReg(3'b101, 8'h66);
      setReg(3'b111, 8'h48);
      srcVal = (c == 7) ? 'h48 : 'h11 * (c + 1);
      execute(8'h80 | 8'(c), 8'h00);
      judge($sformatf("R2 code %0d", c), 'h48, srcVal);
    end

    // memory form with varied pointers
    for (int p = 0; p < 16; p++) begin
      int hv, lv, mv;
      hv = (p * 37 + 1) % 256; lv = (p * 91 + 200) % 256; mv = (p * 53 + 9) % 256;
      setReg(3'b100, 8'(hv)); setReg(3'b101, 8'(lv)); setReg(3'b111, 8'(p * 16));
      execute(8'h86, 8'(mv));
      check(rdAddr == hv * 256 + lv && rdImm == 0, "R4 pointer sweep", rdAddr, hv * 256 + lv);
      judge("R4 mem sweep", p * 16, mv);
    end

    // discarded opcodes
    setReg(3'b111, 8'h5A);
    execute(8'h80, 8'h00);  // establish known flags
    for (int k = 0; k < 6; k++) begin
      logic [7:0] badOp;
      logic [7:0] keepA, keepF;
      case (k)
        0: badOp = 8'h00; 1: badOp = 8'h88; 2: badOp = 8'hC7;
        3: badOp = 8'h76; 4: badOp = 8'hFF; default: badOp = 8'h90;
      endcase
      keepA = accOut; keepF = flagsOut;
      issue(badOp);
      sawDone = 1'b0;
      for (int w = 0; w < 8; w++) begin
        if (done || !opReady) sawDone = 1'b1;
        @(negedge clk);
      end
      check(!sawDone, "R9 discarded opcode stays idle", sawDone, 0);
      check(accOut == keepA && flagsOut == keepF, "R9 discarded opcode no change",
            {accOut, flagsOut}, {keepA, keepF});
    end

    // opValid while busy is ignored
    setReg(3'b111, 8'h01); setReg(3'b000, 8'h02);
    issue(8'h80);
    check(!opReady, "R10 busy drops ready", opReady, 0);
    opValid = 1'b1; opByte = 8'hC6;
    while (!done) @(negedge clk);
    @(negedge clk);
    opValid = 1'b0;
    check(accOut == 8'h03, "R10 first instruction result", accOut, 3);
    sawDone = 1'b0;
    for (int w = 0; w < 10; w++) begin
      if (done || memRd) sawDone = 1'b1;
      @(negedge clk);
    end
    check(!sawDone, "R10 no second instruction", sawDone, 0);

    // write-port collisions on the write-back edge
    setReg(3'b111, 8'h10); setReg(3'b000, 8'h05); setReg(3'b001, 8'h00);
    issue(8'h80);
    while (!done) @(negedge clk);
    regWrEn = 1'b1; regWrSel = 3'b111; regWrData = 8'h99;
    @(negedge clk);
    regWrEn = 1'b0;
    check(accOut == 8'h15, "R11 write-back wins over A write", accOut, 'h15);

    setReg(3'b111, 8'h20);
    issue(8'h80);
    while (!done) @(negedge clk);
    regWrEn = 1'b1; regWrSel = 3'b001; regWrData = 8'h22;
    @(negedge clk);
    regWrEn = 1'b0;
    check(accOut == 8'h25, "R11 sum with concurrent C write", accOut, 'h25);
    setReg(3'b111, 8'h00);
    execute(8'h81, 8'h00);
    expA = 'h22;
    check(int'(accOut) == expA, "R11 C write landed", accOut, expA);

    // flags hold between instructions
    setReg(3'b111, 8'hFF); setReg(3'b000, 8'h01);
    execute(8'h80, 8'h00);
    setReg(3'b111, 8'h33);
    check(flagsOut == 8'h51, "R8 flags kept across register writes", flagsOut, 'h51);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule